// File: doc/BRIEF.md
# I2C Interrupt Request Flag Logic

This block decides when the single interrupt-request flag of an I2C controller is raised. An existing bit engine feeds it one-cycle event pulses: start seen, stop seen, the falling edge of the 8th SCL clock, the rising edge of the 9th SCL clock, a sampled acknowledge bit, arbitration lost, own-address match and general-call match. Software supplies a few configuration bits. The block combines these into one sticky flag. It also gives a level interrupt line, a copy of the last received acknowledge bit, and a general-call status bit.

In master mode the flag marks the start of the first frame and the end of each byte. The byte end is taken at the 8th clock fall when wait insertion is on, and at the 9th clock rise when it is off. In slave mode an own-address or general-call match opens an active window. While the window is open, each 9th clock rise raises the flag. The window closes on the next start (including a repeated start) or stop. NACK, arbitration loss and stop events each have their own enable or mask. Software clears the flag by reading it as 1 and then writing 0. An event in the same cycle as the clear wins.

Top module: `i2cIrqFlag`

## Requirements
- R1: After reset, irqFlag, irqOut, ackStatus, gcStatus and slaveActive are all 0.
- R2: In master mode (masterMode=1), a startSeen pulse sets irqFlag on the next clock edge.
- R3: In master mode with waitEn=1, a sclFall8 pulse sets irqFlag and a sclRise9 pulse does not. With waitEn=0, sclRise9 sets it and sclFall8 does not.
- R4: Each ackValid pulse loads ackBit into ackStatus. irqFlag is set by ackValid with ackBit=1 (NACK) only when ackChkEn=1.
- R5: An arbLost pulse sets irqFlag only when arbIrqEn=1.
- R6: After an arbLost pulse, the first sclRise9 following the next startSeen sets irqFlag, whatever arbIrqEn and masterMode are. This stays in force until a stopSeen pulse.
- R7: An addrMatch pulse sets irqFlag and slaveActive. With masterMode=0 and slaveActive=1, each sclRise9 sets irqFlag. A startSeen or stopSeen pulse clears slaveActive.
- R8: A gcMatch pulse with rwBit=0 sets gcStatus, slaveActive and irqFlag. With rwBit=1 it has no effect. gcStatus is cleared by startSeen or stopSeen.
- R9: A stopSeen pulse sets irqFlag only when stopMask=0.
- R10: A clrWr with clrVal=0 clears irqFlag only if rdStrobe has seen irqFlag=1 since the last write. A clrWr with clrVal=1 does nothing. A set event in the same cycle as a clear keeps irqFlag at 1. Events in the same cycle are OR-combined.
- R11: irqOut is 1 exactly when irqFlag=1 and globalIrqEn=1.
- R12: With masterMode=0 and slaveActive=0, a sclRise9 pulse does not set irqFlag, unless R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = master, 0 = slave |
| waitEn | input | 1 | Wait insertion enable (byte end at 8th fall) |
| ackChkEn | input | 1 | Raise flag on received NACK |
| arbIrqEn | input | 1 | Raise flag on arbitration loss |
| stopMask | input | 1 | 1 = stop does not raise flag |
| globalIrqEn | input | 1 | Gates irqOut |
| startSeen | input | 1 | Start or repeated start pulse |
| stopSeen | input | 1 | Stop pulse |
| sclFall8 | input | 1 | 8th SCL falling edge pulse |
| sclRise9 | input | 1 | 9th SCL rising edge pulse |
| ackValid | input | 1 | Acknowledge bit sampled |
| ackBit | input | 1 | Sampled acknowledge value (1 = NACK) |
| arbLost | input | 1 | Arbitration lost pulse |
| addrMatch | input | 1 | Own slave address matched |
| gcMatch | input | 1 | General-call address seen |
| rwBit | input | 1 | R/W bit of the address frame |
| rdStrobe | input | 1 | Software read of the flag |
| clrWr | input | 1 | Software write of the flag |
| clrVal | input | 1 | Value written |
| irqFlag | output | 1 | Sticky interrupt-request flag |
| irqOut | output | 1 | Level interrupt |
| ackStatus | output | 1 | Last received acknowledge bit |
| gcStatus | output | 1 | General-call received |
| slaveActive | output | 1 | Slave active window open |

## Verification
Directed sequences drive each event alone under both settings of its enable or mode bit. This shows whether the gating selects the right source, for example 8th fall against 9th rise under waitEn, or an open against a closed slave window. A sweep then walks all 64 combinations of the six mode and enable bits. In each combination it applies sparse, overlapping event pulses, reads and writes. A model derived from the requirements checks every output each cycle. This exposes wrong priority between same-cycle set and clear, and wrong window or arbitration-lost state carried across bytes.

// File: rtl/irqEvtPkg.sv
package irqEvtPkg;
  localparam int SRC_COUNT = 8;

  typedef struct packed {
    logic setFlag;
    logic clrReq;
    logic rdMark;
    logic ackLoad;
    logic gcSet;
    logic gcClr;
  } irqStrobeT;
endpackage

// File: rtl/irqEvtCtrl.sv
module irqEvtCtrl
  import irqEvtPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  logic      waitEn,
  input  logic      ackChkEn,
  input  logic      arbIrqEn,
  input  logic      stopMask,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      sclFall8,
  input  logic      sclRise9,
  input  logic      ackValid,
  input  logic      ackBit,
  input  logic      arbLost,
  input  logic      addrMatch,
  input  logic      gcMatch,
  input  logic      rwBit,
  input  logic      rdStrobe,
  input  logic      clrWr,
  input  logic      clrVal,
  output irqStrobeT strb,
  output logic      slaveActive
);
  logic firstFrame;
  logic arbHeld;
  logic gcHit;
  logic windowClose;
  logic byteEnd;
  logic [SRC_COUNT-1:0] setSrc;

  assign gcHit       = gcMatch && !rwBit;
  assign windowClose = startSeen || stopSeen;
  assign byteEnd     = waitEn ? sclFall8 : sclRise9;

  always_comb begin
    setSrc    = '0;
    setSrc[0] = masterMode && startSeen;
    setSrc[1] = masterMode && byteEnd;
    setSrc[2] = ackChkEn && ackValid && ackBit;
    setSrc[3] = arbIrqEn && arbLost;
    setSrc[4] = arbHeld && firstFrame && sclRise9;
    setSrc[5] = addrMatch || gcHit;
    setSrc[6] = !masterMode && slaveActive && sclRise9;
    setSrc[7] = stopSeen && !stopMask;
  end

  always_comb begin
    strb.setFlag = |setSrc;
    strb.clrReq  = clrWr && !clrVal;
    strb.rdMark  = rdStrobe;
    strb.ackLoad = ackValid;
    strb.gcSet   = gcHit;
    strb.gcClr   = windowClose;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveActive <= 1'b0;
      firstFrame  <= 1'b0;
      arbHeld     <= 1'b0;
    end else begin
      if (windowClose)                slaveActive <= 1'b0;
      else if (addrMatch || gcHit)    slaveActive <= 1'b1;
      if (startSeen)                  firstFrame <= 1'b1;
      else if (sclRise9)              firstFrame <= 1'b0;
      if (stopSeen)                   arbHeld <= 1'b0;
      else if (arbLost)               arbHeld <= 1'b1;
    end
  end

  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    windowClose |=> !slaveActive) else $error("window not closed"); // R7

  AST_STOP_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && stopMask && !startSeen && !sclFall8 && !sclRise9 && !ackValid &&
     !arbLost && !addrMatch && !gcMatch) |-> !strb.setFlag) else $error("masked stop set"); // R9
endmodule

// File: rtl/irqEvtData.sv
module irqEvtData
  import irqEvtPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  irqStrobeT strb,
  input  logic      ackBit,
  input  logic      globalIrqEn,
  output logic      irqFlag,
  output logic      irqOut,
  output logic      ackStatus,
  output logic      gcStatus
);
  logic readSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag   <= 1'b0;
      readSeen  <= 1'b0;
      ackStatus <= 1'b0;
      gcStatus  <= 1'b0;
    end else begin
      if (strb.setFlag)                   irqFlag <= 1'b1;
      else if (strb.clrReq && readSeen)   irqFlag <= 1'b0;
      if (strb.clrReq)                    readSeen <= 1'b0;
      else if (strb.rdMark && irqFlag)    readSeen <= 1'b1;
      if (strb.ackLoad)                   ackStatus <= ackBit;
      if (strb.gcClr)                     gcStatus <= 1'b0;
      else if (strb.gcSet)                gcStatus <= 1'b1;
    end
  end

  assign irqOut = irqFlag && globalIrqEn;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> irqFlag) else $error("set lost"); // R10

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(strb.setFlag)) else $error("spurious set"); // R10

  AST_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> ($past(readSeen) && $past(strb.clrReq))) else $error("clear w/o read"); // R10

  AST_ACK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackLoad |=> (ackStatus == $past(ackBit))) else $error("ack not loaded"); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> !irqOut) else $error("irq leaks"); // R11
endmodule

// File: rtl/i2cIrqFlag.sv
module i2cIrqFlag
  import irqEvtPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic masterMode,
  input  logic waitEn,
  input  logic ackChkEn,
  input  logic arbIrqEn,
  input  logic stopMask,
  input  logic globalIrqEn,
  input  logic startSeen,
  input  logic stopSeen,
  input  logic sclFall8,
  input  logic sclRise9,
  input  logic ackValid,
  input  logic ackBit,
  input  logic arbLost,
  input  logic addrMatch,
  input  logic gcMatch,
  input  logic rwBit,
  input  logic rdStrobe,
  input  logic clrWr,
  input  logic clrVal,
  output logic irqFlag,
  output logic irqOut,
  output logic ackStatus,
  output logic gcStatus,
  output logic slaveActive
);
  irqStrobeT strb;

  irqEvtCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .waitEn(waitEn),
    .ackChkEn(ackChkEn), .arbIrqEn(arbIrqEn), .stopMask(stopMask),
    .startSeen(startSeen), .stopSeen(stopSeen), .sclFall8(sclFall8),
    .sclRise9(sclRise9), .ackValid(ackValid), .ackBit(ackBit),
    .arbLost(arbLost), .addrMatch(addrMatch), .gcMatch(gcMatch),
    .rwBit(rwBit), .rdStrobe(rdStrobe), .clrWr(clrWr), .clrVal(clrVal),
    .strb(strb), .slaveActive(slaveActive)
  );

  irqEvtData data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ackBit(ackBit),
    .globalIrqEn(globalIrqEn), .irqFlag(irqFlag), .irqOut(irqOut),
    .ackStatus(ackStatus), .gcStatus(gcStatus)
  );
endmodule

// File: tb/i2cIrqFlag_tb_top.sv
`timescale 1ns/1ps
module i2cIrqFlag_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 0, waitEn = 0, ackChkEn = 0, arbIrqEn = 0, stopMask = 0, globalIrqEn = 0;
  logic startSeen = 0, stopSeen = 0, sclFall8 = 0, sclRise9 = 0, ackValid = 0, ackBit = 0;
  logic arbLost = 0, addrMatch = 0, gcMatch = 0, rwBit = 0, rdStrobe = 0, clrWr = 0, clrVal = 0;
  logic irqFlag, irqOut, ackStatus, gcStatus, slaveActive;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference state
  logic mFlag = 0, mRead = 0, mAck = 0, mGc = 0, mSlave = 0, mFirst = 0, mArb = 0;

  always #10 clk = ~clk;

  i2cIrqFlag dut_i (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clrEv();
    startSeen = 0; stopSeen = 0; sclFall8 = 0; sclRise9 = 0; ackValid = 0; ackBit = 0;
    arbLost = 0; addrMatch = 0; gcMatch = 0; rwBit = 0; rdStrobe = 0; clrWr = 0; clrVal = 0;
  endtask

  task automatic step();
    logic set, gcHit, nFlag, nRead, nAck, nGc, nSlave, nFirst, nArb;
    gcHit = gcMatch && !rwBit;
    set = (masterMode && startSeen)
       || (masterMode && (waitEn ? sclFall8 : sclRise9))
       || (ackChkEn && ackValid && ackBit)
       || (arbIrqEn && arbLost)
       || (mArb && mFirst && sclRise9)
       || addrMatch || gcHit
       || (!masterMode && mSlave && sclRise9)
       || (stopSeen && !stopMask);
    nFlag = set ? 1'b1 : ((clrWr && !clrVal && mRead) ? 1'b0 : mFlag);
    nRead = (clrWr && !clrVal) ? 1'b0 : ((rdStrobe && mFlag) ? 1'b1 : mRead);
    nAck = ackValid ? ackBit : mAck;
    nGc = (startSeen || stopSeen) ? 1'b0 : (gcHit ? 1'b1 : mGc);
    nSlave = (startSeen || stopSeen) ? 1'b0 : ((addrMatch || gcHit) ? 1'b1 : mSlave);
    nFirst = startSeen ? 1'b1 : (sclRise9 ? 1'b0 : mFirst);
    nArb = stopSeen ? 1'b0 : (arbLost ? 1'b1 : mArb);
    @(posedge clk);
    if (rstN) begin
      mFlag = nFlag; mRead = nRead; mAck = nAck; mGc = nGc;
      mSlave = nSlave; mFirst = nFirst; mArb = nArb;
    end
    @(negedge clk);
    chk("R10 model flag", irqFlag, mFlag);
    chk("R11 model irqOut", irqOut, mFlag && globalIrqEn);
    chk("R4 model ackStatus", ackStatus, mAck);
    chk("R8 model gcStatus", gcStatus, mGc);
    chk("R7 model slaveActive", slaveActive, mSlave);
    clrEv();
  endtask

  task automatic clearFlag();
    rdStrobe = 1; step();
    clrWr = 1; clrVal = 0; step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irqFlag", irqFlag, 0); chk("R1 irqOut", irqOut, 0);
    chk("R1 ackStatus", ackStatus, 0); chk("R1 gcStatus", gcStatus, 0);
    chk("R1 slaveActive", slaveActive, 0);
    rstN = 1;
    step();

    // R2 master start
    masterMode = 1; startSeen = 1; step();
    chk("R2 start sets", irqFlag, 1);
    clearFlag(); chk("R10 read then clear", irqFlag, 0);

    // R3 wait mode selects 8th fall
    waitEn = 1; sclRise9 = 1; step(); chk("R3 wait: rise9 ignored", irqFlag, 0);
    sclFall8 = 1; step(); chk("R3 wait: fall8 sets", irqFlag, 1);
    clearFlag();
    waitEn = 0; sclFall8 = 1; step(); chk("R3 nowait: fall8 ignored", irqFlag, 0);
    sclRise9 = 1; step(); chk("R3 nowait: rise9 sets", irqFlag, 1);

    // R10 clear rules
    clrWr = 1; clrVal = 0; step(); chk("R10 clear without read", irqFlag, 1);
    rdStrobe = 1; step();
    clrWr = 1; clrVal = 1; step(); chk("R10 write 1 no effect", irqFlag, 1);
    rdStrobe = 1; step();
    clrWr = 1; clrVal = 0; sclRise9 = 1; step(); chk("R10 set beats clear", irqFlag, 1);
    clearFlag(); chk("R10 cleared", irqFlag, 0);
    masterMode = 0;

    // R4 ack check
    ackValid = 1; ackBit = 1; step();
    chk("R4 nack disabled", irqFlag, 0); chk("R4 ack loaded", ackStatus, 1);
    ackChkEn = 1; ackValid = 1; ackBit = 1; step(); chk("R4 nack enabled", irqFlag, 1);
    clearFlag();
    ackValid = 1; ackBit = 0; step();
    chk("R4 ack 0 no set", irqFlag, 0); chk("R4 ack 0 loaded", ackStatus, 0);
    ackChkEn = 0;

    // R5 / R6 arbitration
    arbLost = 1; step(); chk("R5 arb disabled", irqFlag, 0);
    startSeen = 1; step(); chk("R6 start in slave no set", irqFlag, 0);
    sclRise9 = 1; step(); chk("R6 address after loss", irqFlag, 1);
    clearFlag();
    sclRise9 = 1; step(); chk("R6 only first frame", irqFlag, 0);
    stopMask = 1; stopSeen = 1; step(); chk("R9 masked stop", irqFlag, 0);
    stopMask = 0; stopSeen = 1; step(); chk("R9 unmasked stop", irqFlag, 1);
    clearFlag();
    startSeen = 1; step(); sclRise9 = 1; step(); chk("R6 ended by stop", irqFlag, 0);
    arbIrqEn = 1; arbLost = 1; step(); chk("R5 arb enabled", irqFlag, 1);
    clearFlag(); arbIrqEn = 0;
    stopMask = 1; stopSeen = 1; step();

    // R7 / R12 slave window
    sclRise9 = 1; step(); chk("R12 no window", irqFlag, 0);
    addrMatch = 1; step(); chk("R7 match sets", irqFlag, 1); chk("R7 window open", slaveActive, 1);
    clearFlag();
    sclRise9 = 1; step(); chk("R7 byte in window", irqFlag, 1);
    clearFlag();
    stopSeen = 1; step(); chk("R7 stop closes", slaveActive, 0);
    sclRise9 = 1; step(); chk("R12 closed window", irqFlag, 0);

    // R8 general call
    gcMatch = 1; rwBit = 1; step();
    chk("R8 read gc ignored flag", irqFlag, 0); chk("R8 read gc ignored status", gcStatus, 0);
    gcMatch = 1; rwBit = 0; step();
    chk("R8 gc flag", irqFlag, 1); chk("R8 gc status", gcStatus, 1);
    clearFlag();
    startSeen = 1; step();
    chk("R8 restart clears gc", gcStatus, 0); chk("R7 restart closes", slaveActive, 0);

    // R11 gating
    addrMatch = 1; step();
    chk("R11 gated off", irqOut, 0);
    globalIrqEn = 1; step(); chk("R11 enabled", irqOut, 1);
    clearFlag(); chk("R11 low after clear", irqOut, 0);
    stopSeen = 1; step();

    // Sweep: all 64 mode/enable combos with sparse pulses (R10 OR-combining)
    lfsr = 32'hACE1_2357;
    for (int cfg = 0; cfg < 64; cfg++) begin
      {masterMode, waitEn, ackChkEn, arbIrqEn, stopMask, globalIrqEn} = cfg[5:0];
      for (int k = 0; k < 48; k++) begin
        for (int s = 0; s < 3; s++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        startSeen = &lfsr[2:0] & lfsr[31];
        stopSeen  = &lfsr[5:3] & lfsr[30];
        sclFall8  = &lfsr[7:6];
        sclRise9  = &lfsr[9:8];
        ackValid  = &lfsr[11:10]; ackBit = lfsr[12];
        arbLost   = &lfsr[15:13];
        addrMatch = &lfsr[18:16];
        gcMatch   = &lfsr[21:19]; rwBit = lfsr[22];
        rdStrobe  = lfsr[23] & lfsr[24];
        clrWr     = &lfsr[27:25]; clrVal = lfsr[28];
        step();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule